// File: doc/BRIEF.md
# DTMF Steering Controller with Latched Code Output

This block takes the place of an external resistor-capacitor steering network in a tone receiver. A frequency classifier upstream raises an early-steering flag while it sees a valid tone pair and presents the matching 4-bit key code. This block registers a digit only after that flag has stayed high for a programmable tone-present guard time. It then loads the code into an output latch and, after a short settle delay, raises a delayed-steering flag. The flag falls only after the early flag has stayed low for a separate tone-absent guard time. Until then, the receiver stays committed to the current digit.

Short bursts are rejected and short dropouts are bridged. The latched code stays in place until the next digit is registered. A tri-stated 4-bit bus shows the latched code whenever output-enable is high. An inhibit input blocks the fourth-column keys. A power-down input halts detection. All guard times are clock-count parameters. The total recognition time is the classifier's detection time plus the tone-present guard time. With the default 50 MHz clock, this keeps recognition near 40 ms.

Top module: `dtmf_steer`

## Requirements
- R1: A digit is registered (code latched) only on the TP_CYC-th consecutive clock edge at which early-steering is sampled high and the tone is qualified. Any shorter burst leaves the bus and the delayed-steering flag unchanged.
- R2: The code is latched at the registering edge. The delayed-steering flag rises exactly SETTLE_CYC clock edges later, so the data is valid before the flag.
- R3: After a registered digit, the delayed-steering flag falls on the TA_CYC-th consecutive edge at which early-steering is sampled low.
- R4: A low period of early-steering lasting fewer than TA_CYC edges keeps the flag high and the latched code unchanged. A changed key code during that time is not registered.
- R5: The latched code is held after the tone ends, until the next digit is registered.
- R6: With output-enable low, the bus is high impedance (4'bzzzz). With it high, the bus shows the latched code. The latch keeps updating while the bus is disabled.
- R7: With inhibit high, fourth-column codes are never registered and the previous code is kept. Fourth-column codes are 4'd13, 4'd14, 4'd15 and 4'd0.
- R8: Power-down high returns the controller to idle and clears the delayed-steering flag on the next edge. It keeps the latched code and prevents any registration while it is high.
- R9: After reset, the latched code is 4'd0 and the delayed-steering flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| early_st | input | 1 | Early-steering flag from the classifier |
| key_code | input | 4 | Key code from the classifier |
| out_en | input | 1 | Enable for the tri-stated code bus |
| col4_inhibit | input | 1 | Blocks registration of fourth-column keys |
| pwr_down | input | 1 | Halts detection and clears the delayed flag |
| code_bus | output | 4 | Tri-stated latched key code |
| dly_steer | output | 1 | Delayed-steering flag |

## Verification
The bench builds the block with TP_CYC=5, TA_CYC=4 and SETTLE_CYC=2. At these values, every burst length below the present guard can be swept, along with the exact edges where the latch loads and the flag rises and falls. All sixteen codes are registered with inhibit both low and high. Dropouts one cycle short of the absent guard, power-down during a held digit, and registration behind a disabled bus are exercised against counts computed in the bench.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_QUALIFY = 3'd1,
    ST_LATCH   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4
  } steer_state_e;

  // Keys in the 1633 Hz column: A=13, B=14, C=15, D=0
  function automatic logic is_fourth_col(input logic [3:0] code);
    return (code == 4'd0) || (code >= 4'd13);
  endfunction

  // True on the sample that completes a window of lim consecutive cycles
  function automatic logic guard_hit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

endpackage

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign done = run && guard_hit(32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (done)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < LIMIT); // R3

endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              out_en,
  output logic [CODE_W-1:0] bus
);
  logic [CODE_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (load) held_q <= code_in;
  end

  assign bus = out_en ? held_q : {CODE_W{1'bz}};

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_q)); // R5

endmodule

// File: rtl/dtmf_steer_fsm.sv
module dtmf_steer_fsm
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act,
  input  logic         pwr_down,
  input  logic         p_done,
  input  logic         a_done,
  output logic         p_run,
  output logic         a_run,
  output logic         lat_load,
  output logic         dly_steer,
  output steer_state_e state
);
  localparam int unsigned SW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);

  steer_state_e st_q, st_d;
  logic [SW-1:0] settle_q;
  logic          dstd_q;
  logic          settle_end;

  assign state      = st_q;
  assign dly_steer  = dstd_q;
  assign settle_end = guard_hit(32'(settle_q), SETTLE_CYC);
  assign p_run      = act  && (st_q == ST_IDLE || st_q == ST_QUALIFY);
  assign a_run      = !act && (st_q == ST_HOLD || st_q == ST_RELEASE);

  always_comb begin
    st_d     = st_q;
    lat_load = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_QUALIFY: begin
        if (!act)        st_d = ST_IDLE;
        else if (p_done) begin
          lat_load = 1'b1;
          st_d     = ST_LATCH;
        end else         st_d = ST_QUALIFY;
      end
      ST_LATCH:   if (settle_end) st_d = ST_HOLD;
      ST_HOLD:    if (!act) st_d = a_done ? ST_IDLE : ST_RELEASE;
      ST_RELEASE: begin
        if (act)         st_d = ST_HOLD;
        else if (a_done) st_d = ST_IDLE;
      end
      default:           st_d = ST_IDLE;
    endcase
    if (pwr_down) begin
      st_d     = ST_IDLE;
      lat_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      settle_q <= '0;
      dstd_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      settle_q <= (st_q == ST_LATCH && !settle_end) ? settle_q + 1'b1 : '0;
      dstd_q   <= (st_d == ST_HOLD) || (st_d == ST_RELEASE);
    end
  end

  AST_RISE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstd_q) |-> $past(st_q) == ST_LATCH); // R2

  AST_LOAD_ON_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_load |-> p_done); // R1

  AST_LOAD_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lat_load |-> !dstd_q); // R2

endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned TP_CYC     = 1_500_000,
  parameter int unsigned TA_CYC     = 1_000_000,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       early_st,
  input  logic [3:0] key_code,
  input  logic       out_en,
  input  logic       col4_inhibit,
  input  logic       pwr_down,
  output logic [3:0] code_bus,
  output logic       dly_steer
);
  logic         act;
  logic         p_run, a_run, p_done, a_done, lat_load;
  steer_state_e state;

  // qualified tone: present, not powered down, not an inhibited column
  assign act = early_st && !pwr_down && !(col4_inhibit && is_fourth_col(key_code));

  dtmf_guard_timer #(.LIMIT(TP_CYC)) present_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(p_run), .done(p_done));

  dtmf_guard_timer #(.LIMIT(TA_CYC)) absent_tmr_i (
    .clk(clk), .rst_n(rst_n), .run(a_run), .done(a_done));

  dtmf_steer_fsm #(.SETTLE_CYC(SETTLE_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .act(act), .pwr_down(pwr_down),
    .p_done(p_done), .a_done(a_done), .p_run(p_run), .a_run(a_run),
    .lat_load(lat_load), .dly_steer(dly_steer), .state(state));

  dtmf_code_latch #(.CODE_W(4)) latch_i (
    .clk(clk), .rst_n(rst_n), .load(lat_load), .code_in(key_code),
    .out_en(out_en), .bus(code_bus));

  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !dly_steer); // R8

  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_load && col4_inhibit) |-> !is_fourth_col(key_code)); // R7

  AST_FALL_ON_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dly_steer) |-> ($past(a_done) || $past(pwr_down))); // R3

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dly_steer |-> (state == ST_HOLD || state == ST_RELEASE)); // R4

endmodule

// File: tb/dtmf_steer_tb_top.sv
`timescale 1ns/1ps
module dtmf_steer_tb_top;
  localparam int TP = 5;
  localparam int TA = 4;
  localparam int ST = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       est = 1'b0;
  logic [3:0] code = 4'd0;
  logic       oe = 1'b1;
  logic       inh = 1'b0;
  logic       pd = 1'b0;
  wire  [3:0] bus;
  wire        dstd;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_q = 4'd0;

  always #10 clk = ~clk;

  dtmf_steer #(.TP_CYC(TP), .TA_CYC(TA), .SETTLE_CYC(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .early_st(est), .key_code(code), .out_en(oe),
    .col4_inhibit(inh), .pwr_down(pd), .code_bus(bus), .dly_steer(dstd));

  function automatic logic col4(input logic [3:0] c);
    case (c)
      4'hD, 4'hE, 4'hF, 4'h0: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  task automatic chk_q(input string req, input logic [3:0] e);
    logic [3:0] want;
    want = oe ? e : 4'bzzzz;
    n_chk++;
    if (bus !== want) begin
      n_bad++;
      $display("FAIL %s bus=%b expected=%b t=%0t", req, bus, want, $time);
    end
  endtask

  task automatic chk_d(input string req, input logic e);
    n_chk++;
    if (dstd !== e) begin
      n_bad++;
      $display("FAIL %s dly_steer=%b expected=%b t=%0t", req, dstd, e, $time);
    end
  endtask

  // tone of len cycles; acc says whether it must register
  task automatic tone(input logic [3:0] c, input int len, input logic acc);
    logic [3:0] prev;
    prev = exp_q;
    code = c;
    est  = 1'b1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      chk_q(i < TP ? "R1" : (acc ? "R2" : "R7"), (acc && i >= TP) ? c : prev);
      chk_d(i < TP + ST ? "R2" : "R1", acc && i >= TP + ST);
    end
    if (acc) exp_q = c;
  endtask

  task automatic release_tone(input logic was_reg);
    est = 1'b0;
    for (int j = 1; j <= TA + 1; j++) begin
      @(negedge clk);
      chk_d("R3", was_reg && j < TA);
      chk_q("R5", exp_q);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_q("R9", 4'd0);
    chk_d("R9", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_q("R9", 4'd0);
    chk_d("R9", 1'b0);

    // R1: every burst length below the guard is rejected
    for (int l = 1; l < TP; l++) begin
      tone(4'(l + 3), l, 1'b0);
      release_tone(1'b0);
    end

    // R7 sweep: all codes with inhibit low then high
    for (int ih = 0; ih < 2; ih++) begin
      inh = ih[0];
      for (int c = 0; c < 16; c++) begin
        logic acc;
        acc = !(inh && col4(4'(c)));
        tone(4'(c), TP + ST + 3, acc);
        release_tone(acc);
      end
    end
    inh = 1'b0;

    // R4: dropout one short of the absent guard is bridged
    tone(4'd5, TP + ST + 2, 1'b1);
    est = 1'b0;
    for (int j = 1; j < TA; j++) begin
      @(negedge clk);
      chk_d("R4", 1'b1);
      chk_q("R4", 4'd5);
    end
    est  = 1'b1;
    code = 4'd9;
    for (int j = 0; j < TP + 2; j++) begin
      @(negedge clk);
      chk_d("R4", 1'b1);
      chk_q("R4", 4'd5);
    end
    release_tone(1'b1);

    // R6: bus disabled, latch still updates
    oe = 1'b0;
    @(negedge clk);
    chk_q("R6", exp_q);
    tone(4'd3, TP + ST + 1, 1'b1);
    release_tone(1'b1);
    oe = 1'b1;
    @(negedge clk);
    chk_q("R6", 4'd3);

    // R8: power-down during a held digit
    tone(4'd6, TP + ST + 1, 1'b1);
    pd = 1'b1;
    @(negedge clk);
    chk_d("R8", 1'b0);
    chk_q("R8", 4'd6);
    est = 1'b0;
    repeat (2) @(negedge clk);
    code = 4'd2;
    est  = 1'b1;
    for (int j = 0; j < TP + ST + 3; j++) begin
      @(negedge clk);
      chk_d("R8", 1'b0);
      chk_q("R8", 4'd6);
    end
    est = 1'b0;
    @(negedge clk);
    pd = 1'b0;
    release_tone(1'b0);

    // R5: a fresh digit after power-down registers normally
    tone(4'd8, TP + ST + 1, 1'b1);
    release_tone(1'b1);
    repeat (5) @(negedge clk);
    chk_q("R5", 4'd8);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule